// File: doc/BRIEF.md
# Microprogrammed State Sequencer with OR-Merged Branching

This block steps through a fixed microprogram held in an internal control store. It reads the microword at the current microaddress. A select field in that word picks zero, one or two bits from a 4-bit condition input. The picked bits are ORed into the low end of the word's successor field, and the result becomes the next microaddress on the following rising clock edge. The block needs no adder and no second jump-target field. A word that does not branch takes one store location, because select code 0 feeds constant zeros into the OR.

Each microword also carries a group of control bits. These are registered so that they always belong to the word at the address shown on the debug output. The store contents are computed in the source when the design is elaborated. Branch successors are placed on boundaries whose low bits are clear, so the OR always lands on bits that are zero.

Top module: `useq_sequencer`

## Requirements
- R1: Reset is synchronous. At any rising edge where `rst_i` is high, `uaddr_o` becomes 0 and `ctrl_o` becomes the control field of word 0, whatever `cond_i` holds.
- R2: The store has 64 words with a 6-bit address. Word a has select s = a mod 8 and control field (37a + 11) mod 256. Its successor field is (5a + 3) mod 64, with its low w bits cleared, where w is the branch width of s.
- R3: Select code 0 never branches. The next address equals the successor field, and `cond_i` has no effect on it.
- R4: Select codes 1, 2, 3 and 4 have branch width 1. They OR `cond_i[0]`, `cond_i[1]`, `cond_i[2]` and `cond_i[3]` respectively into address bit 0.
- R5: Select codes 5 and 6 have branch width 2. Code 5 ORs `cond_i[1:0]` into address bits 1:0, and code 6 ORs `cond_i[3:2]` into them.
- R6: Select code 7 is reserved and behaves exactly like code 0.
- R7: Address bits above the branch width of the current word always equal the successor field. A 1-bit branch never alters bit 1.
- R8: Every branching word has its successor field clear in the bits that its branch width covers. With all selected condition bits at 0, the next address therefore has those low bits at 0.
- R9: `cond_i` is sampled at each rising edge. `uaddr_o` and `ctrl_o` change together on that same edge. `ctrl_o` always equals the control field of the word at `uaddr_o`, and the sequencer advances on every cycle that is not in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | External condition bits, selected by the current microword |
| ctrl_o | output | CTRL_W (8) | Registered control field of the current microword |
| uaddr_o | output | ADDR_W (6) | Current microaddress, brought out for debug |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The condition bits present before an edge decide the address and control word that are visible after that edge. Reset asserted before an edge yields address 0 after it. The bench drives conditions and reset on the falling edge and samples both outputs on the next falling edge. That sampling point lies one register stage after the decision edge, and the bench compares it against its own model state, which it advances once per cycle. A coverage tally confirms that each of the eight select codes was met with all sixteen condition patterns.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned COND_W = 4;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE    = 3'd0,
    SEL_C0      = 3'd1,
    SEL_C1      = 3'd2,
    SEL_C2      = 3'd3,
    SEL_C3      = 3'd4,
    SEL_PAIR_LO = 3'd5,
    SEL_PAIR_HI = 3'd6,
    SEL_RSVD    = 3'd7
  } sel_e;

  // Number of low address bits a select code may set.
  function automatic logic [1:0] branch_width(sel_e s);
    case (s)
      SEL_C0, SEL_C1, SEL_C2, SEL_C3: return 2'd1;
      SEL_PAIR_LO, SEL_PAIR_HI:       return 2'd2;
      default:                        return 2'd0;
    endcase
  endfunction

  // Condition bits routed toward the address OR; code 0 and 7 give zero.
  function automatic logic [1:0] pick_cond(sel_e s, logic [COND_W-1:0] c);
    case (s)
      SEL_C0:      return {1'b0, c[0]};
      SEL_C1:      return {1'b0, c[1]};
      SEL_C2:      return {1'b0, c[2]};
      SEL_C3:      return {1'b0, c[3]};
      SEL_PAIR_LO: return c[1:0];
      SEL_PAIR_HI: return c[3:2];
      default:     return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 8
) (
  input  logic [ADDR_W-1:0] rd_cur_i,
  input  logic [ADDR_W-1:0] rd_nxt_i,
  output logic [ADDR_W-1:0] cur_next_o,
  output sel_e              cur_sel_o,
  output logic [CTRL_W-1:0] nxt_ctrl_o
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = ADDR_W + SEL_W + CTRL_W;

  // Microprogram contents, computed at elaboration.
  function automatic logic [WORD_W-1:0] word_at(int unsigned a);
    int unsigned s;
    int unsigned w;
    int unsigned raw;
    int unsigned base;
    int unsigned ctl;
    s    = a % (1 << SEL_W);
    w    = int'(branch_width(sel_e'(s)));
    raw  = (a * 5 + 3) % DEPTH;
    base = raw & ~((32'd1 << w) - 32'd1);
    ctl  = a * 37 + 11;
    return {ADDR_W'(base), SEL_W'(s), CTRL_W'(ctl)};
  endfunction

  logic [WORD_W-1:0] store [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign store[i] = word_at(i);
  end

  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] nxt_word;

  assign cur_word   = store[rd_cur_i];
  assign nxt_word   = store[rd_nxt_i];
  assign cur_next_o = cur_word[WORD_W-1 -: ADDR_W];
  assign cur_sel_o  = sel_e'(cur_word[CTRL_W +: SEL_W]);
  assign nxt_ctrl_o = nxt_word[CTRL_W-1:0];

endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
  import useq_pkg::*;
(
  input  sel_e              sel_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [1:0]        br_bits_o,
  output logic [1:0]        br_width_o
);

  always_comb begin
    br_bits_o  = pick_cond(sel_i, cond_i);
    br_width_o = branch_width(sel_i);
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        br_bits_i,
  output logic [ADDR_W-1:0] addr_o
);

  // Merge condition bits into the aligned successor; no carry path.
  function automatic logic [ADDR_W-1:0] or_low(logic [ADDR_W-1:0] b, logic [1:0] c);
    return b | ADDR_W'(c);
  endfunction

  assign addr_o = or_low(base_i, br_bits_i);

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] uaddr_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ADDR_W-1:0] cur_next;
  sel_e              cur_sel;
  logic [1:0]        br_bits;
  logic [1:0]        br_width;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] load_addr;
  logic [CTRL_W-1:0] load_ctrl;

  useq_rom #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_rom (
    .rd_cur_i   (addr_q),
    .rd_nxt_i   (load_addr),
    .cur_next_o (cur_next),
    .cur_sel_o  (cur_sel),
    .nxt_ctrl_o (load_ctrl)
  );

  useq_cond_mux u_mux (
    .sel_i      (cur_sel),
    .cond_i     (cond_i),
    .br_bits_o  (br_bits),
    .br_width_o (br_width)
  );

  useq_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .base_i    (cur_next),
    .br_bits_i (br_bits),
    .addr_o    (nxt_addr)
  );

  // Reset steers the load path to word 0 so address and control stay paired.
  assign load_addr = rst_i ? '0 : nxt_addr;

  always_ff @(posedge clk_i) begin
    addr_q <= load_addr;
    ctrl_q <= load_ctrl;
  end

  assign uaddr_o = addr_q;
  assign ctrl_o  = ctrl_q;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] uaddr_o,
  input sel_e              cur_sel,
  input logic [ADDR_W-1:0] cur_next,
  input logic [1:0]        br_width
);

  p_reset_zero_r1: assert property (@(posedge clk_i)
    rst_i |=> (uaddr_o == '0));

  p_no_branch_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_sel == SEL_NONE) |=> (uaddr_o == $past(cur_next)));

  p_single_keeps_bit1_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (br_width == 2'd1) |=> (uaddr_o[1] == $past(cur_next[1])));

  p_reserved_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_sel == SEL_RSVD) |=> (uaddr_o == $past(cur_next)));

  p_upper_kept_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (uaddr_o[ADDR_W-1:2] == $past(cur_next[ADDR_W-1:2])));

  p_aligned_one_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (br_width == 2'd1) |-> (cur_next[0] == 1'b0));

  p_aligned_two_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (br_width == 2'd2) |-> (cur_next[1:0] == 2'b00));

endmodule

bind useq_sequencer useq_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .uaddr_o  (uaddr_o),
  .cur_sel  (cur_sel),
  .cur_next (cur_next),
  .br_width (br_width)
);

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;

  localparam int AW    = 6;
  localparam int CW    = 8;
  localparam int DEPTH = 64;
  localparam int RUN   = 4000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    cond = 4'h0;
  wire  [CW-1:0] ctrl;
  wire  [AW-1:0] uaddr;

  always #5 clk = ~clk;

  useq_sequencer #(.ADDR_W(AW), .CTRL_W(CW)) i_useq_sequencer (
    .clk_i   (clk),
    .rst_i   (rst),
    .cond_i  (cond),
    .ctrl_o  (ctrl),
    .uaddr_o (uaddr)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit seen [8][16];

  // Program description restated from R2.
  function automatic int p_sel(int a);
    return a % 8;
  endfunction

  function automatic int p_width(int s);
    if (s >= 1 && s <= 4) return 1;
    if (s == 5 || s == 6) return 2;
    return 0;
  endfunction

  function automatic int p_succ(int a);
    int w;
    w = p_width(p_sel(a));
    return (((a * 5 + 3) % DEPTH) >> w) << w;
  endfunction

  function automatic int p_ctrl(int a);
    return (a * 37 + 11) % 256;
  endfunction

  // Branch offset per R4/R5; added, since the successor low bits are clear.
  function automatic int p_offset(int s, int c);
    if (s >= 1 && s <= 4) return (c >> (s - 1)) % 2;
    if (s == 5) return c % 4;
    if (s == 6) return (c / 4) % 4;
    return 0;
  endfunction

  function automatic string tag_of(int s);
    if (s == 0) return "R3";
    if (s <= 4) return "R4";
    if (s <= 6) return "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : main
    int model;
    int exp_addr;
    int s;
    int seed;
    int missing;
    seed = 7;
    rst  = 1'b1;
    cond = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(uaddr == 0, "R1 reset address", int'(uaddr), 0);
    check(ctrl == CW'(p_ctrl(0)), "R1 reset control", int'(ctrl), p_ctrl(0));
    rst   = 1'b0;
    model = 0;
    for (int cyc = 0; cyc < RUN; cyc++) begin
      seed = seed * 1103515245 + 12345;
      cond = 4'((seed >>> 16) & 15);
      s    = p_sel(model);
      if (cyc == RUN / 2) begin
        rst      = 1'b1;
        exp_addr = 0;
      end else begin
        seen[s][int'(cond)] = 1'b1;
        exp_addr = p_succ(model) + p_offset(s, int'(cond));
      end
      @(negedge clk);
      if (rst) begin
        check(uaddr == 0, "R1 mid-run reset", int'(uaddr), 0);
        rst = 1'b0;
      end else begin
        check(uaddr == AW'(exp_addr), tag_of(s), int'(uaddr), exp_addr);
        check((uaddr >> 2) == AW'(p_succ(model) >> 2), "R7 upper bits",
              int'(uaddr >> 2), p_succ(model) >> 2);
        if (p_width(s) > 0 && p_offset(s, int'(cond)) == 0)
          check((int'(uaddr) % (1 << p_width(s))) == 0, "R8 aligned target",
                int'(uaddr) % (1 << p_width(s)), 0);
      end
      check(ctrl == CW'(p_ctrl(exp_addr)), "R2 R9 control follows address",
            int'(ctrl), p_ctrl(exp_addr));
      model = exp_addr;
    end
    missing = 0;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 16; b++)
        if (!seen[a][b]) missing++;
    check(missing == 0, "R4 R5 R6 R3 select/condition coverage", missing, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule